// File: doc/BRIEF.md
# Twelve-Channel Low-Side Driver Mode and Fault Controller

This block holds one controller per low-side output channel. Each controller takes its 2-bit command from the serial input register and turns it into a gate-drive level and a diagnostic-current enable. It also latches the faults reported by the analog comparators, which are modelled here as digital flags for overload, over-temperature and open load. The result of each controller is a 2-bit status word, which is placed into the serial output register.

Each channel is a small state machine. Its states are:

| State | Gate | Diagnostic current |
|-------|------|--------------------|
| `ST_PWRUP_OFF` | off | off |
| `ST_STBY` | off | off |
| `ST_RSVD` | off | off |
| `ST_OFF` | off | on |
| `ST_ON` | on | off |
| `ST_TRIP` (fault latched) | off | off |

Its transitions are:

- Any state goes to `ST_STBY` on the standby command.
- A non-tripped state goes to `ST_RSVD`, `ST_ON` or `ST_OFF` on the matching command.
- The off command issued in `ST_PWRUP_OFF` keeps the channel in `ST_PWRUP_OFF`.
- A non-standby command goes to `ST_TRIP` when the overload filter fires or the over-temperature flag is set.
- `ST_TRIP` persists under every command except standby.
- Reset or enable low sends every state to `ST_PWRUP_OFF`.

Each channel owns two persistence timers. One filters the overload flag while the channel is driven. The other qualifies the open-load flag while the channel is off with the diagnostic current on.

Top module: `relay_bank_ctrl`

## Requirements
- R1: While `rst_n` is low, every gate, diagnostic enable and status bit is 0.
- R2: Command encoding per channel (bits 2k+1:2k of `cmd_bus` for channel k) is as follows. 2'b10 turns the gate on at the next clock edge. 2'b00, 2'b01 and 2'b11 hold the gate off.
- R3: The diagnostic current is on only in `ST_OFF`, which is reached by command 2'b11 from any state other than `ST_PWRUP_OFF`. After reset or enable low, command 2'b11 keeps it off until some other command has been applied.
- R4: An overload flag held on a driven channel for `OVL_DLY` consecutive edges turns the gate off at the `OVL_DLY`-th edge. A shorter run does nothing and restarts the count.
- R5: An over-temperature flag trips its channel at the next edge under any command except 2'b00. The other channels are unaffected.
- R6: A tripped channel keeps its gate off and its fault bit set under commands 2'b01, 2'b10 and 2'b11.
- R7: In `status_bus`, bit 2k is the overload/over-temperature fault of channel k and bit 2k+1 is its open-load fault. A 1 means a fault.
- R8: Open load is latched after the flag stays high for `OL_QUAL` consecutive edges in `ST_OFF`. It is never latched in `ST_ON` or `ST_PWRUP_OFF`.
- R9: A latched open load does not stop the channel from turning on. The open-load bit reads 0 while the channel is tripped.
- R10: Command 2'b00 clears both fault bits and turns gate and diagnostic current off at the next edge.
- R11: `enable` low clears all faults and forces every channel into `ST_PWRUP_OFF` at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| enable | input | 1 | Global enable; low clears the bank synchronously |
| cmd_bus | input | 2*NCH | Per-channel 2-bit command from the input register |
| ovl_flag | input | NCH | Per-channel overload comparator flag |
| otemp_flag | input | NCH | Per-channel over-temperature flag |
| open_flag | input | NCH | Per-channel open-load comparator flag |
| gate_on | output | NCH | Per-channel gate drive |
| diag_en | output | NCH | Per-channel diagnostic-current enable |
| status_bus | output | 2*NCH | Per-channel status pair for the output register |

## Verification
Command, over-temperature, standby and enable effects are due one clock edge after the input changes. This is because the channel state register is the only stage on that path. An overload trip is due at exactly the `OVL_DLY`-th edge of a continuous flag, and an open-load latch at the `OL_QUAL`-th edge. Inputs are changed 1 time unit after a rising edge, and outputs are sampled 1 time unit after the edge in which the result is due. The filters are probed one edge short of their limit as well as at it.

// File: rtl/relay_bank_pkg.sv
package relay_bank_pkg;

    typedef enum logic [1:0] {
        CMD_STBY = 2'b00,
        CMD_RSVD = 2'b01,
        CMD_ON   = 2'b10,
        CMD_OFF  = 2'b11
    } chan_cmd_e;

    typedef enum logic [2:0] {
        ST_PWRUP_OFF,
        ST_STBY,
        ST_RSVD,
        ST_OFF,
        ST_ON,
        ST_TRIP
    } chan_state_e;

endpackage

// File: rtl/persist_timer.sv
module persist_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic arm_i,
    output logic fire_o
);
    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr_i || !arm_i)
            cnt <= '0;
        else if (cnt != LAST)
            cnt <= cnt + 1'b1;
    end

    assign fire_o = arm_i && !clr_i && (cnt == LAST);

    // R4
    fire_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |-> $past(arm_i));
endmodule

// File: rtl/relay_chan.sv
module relay_chan
    import relay_bank_pkg::*;
#(
    parameter int OVL_DLY = 48,
    parameter int OL_QUAL = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic [1:0] cmd_i,
    input  logic       ovl_i,
    input  logic       otemp_i,
    input  logic       open_i,
    output logic       gate_o,
    output logic       diag_o,
    output logic [1:0] status_o
);
    chan_state_e state, nxt;
    chan_cmd_e   cmd;
    logic        ovl_fire, ol_fire, ol_lat, stby_clr;

    assign cmd      = chan_cmd_e'(cmd_i);
    assign stby_clr = !en_i || (cmd == CMD_STBY);

    persist_timer #(.LIMIT(OVL_DLY)) u_ovl_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (stby_clr),
        .arm_i  (ovl_i && (state == ST_ON)),
        .fire_o (ovl_fire)
    );

    persist_timer #(.LIMIT(OL_QUAL)) u_ol_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (stby_clr),
        .arm_i  (open_i && (state == ST_OFF)),
        .fire_o (ol_fire)
    );

    always_comb begin
        nxt = state;
        if (cmd == CMD_STBY)
            nxt = ST_STBY;
        else if (state == ST_TRIP || otemp_i || ovl_fire)
            nxt = ST_TRIP;
        else begin
            unique case (cmd)
                CMD_RSVD: nxt = ST_RSVD;
                CMD_ON:   nxt = ST_ON;
                CMD_OFF:  nxt = (state == ST_PWRUP_OFF) ? ST_PWRUP_OFF : ST_OFF;
                default:  nxt = ST_STBY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_PWRUP_OFF;
        else if (!en_i)
            state <= ST_PWRUP_OFF;
        else
            state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ol_lat <= 1'b0;
        else if (stby_clr)
            ol_lat <= 1'b0;
        else if (ol_fire)
            ol_lat <= 1'b1;
    end

    always_comb begin
        gate_o   = 1'b0;
        diag_o   = 1'b0;
        status_o = {ol_lat, 1'b0};
        unique case (state)
            ST_ON:   gate_o = 1'b1;
            ST_OFF:  diag_o = 1'b1;
            ST_TRIP: status_o = 2'b01;
            ST_PWRUP_OFF, ST_STBY, ST_RSVD: ;
            default: ;
        endcase
    end

    // R11
    en_low_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!gate_o && !diag_o && status_o == 2'b00));

    // R5
    otemp_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && otemp_i && cmd_i != 2'b00) |=> (!gate_o && status_o[0]));

    // R10
    stby_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && cmd_i == 2'b00) |=> (status_o == 2'b00 && !gate_o && !diag_o));

    // R6
    trip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && status_o[0] && cmd_i != 2'b00) |=> (status_o[0] && !gate_o));

    // R2
    gate_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_o) |-> ($past(cmd_i) == 2'b10 && $past(en_i)));
endmodule

// File: rtl/relay_bank_ctrl.sv
module relay_bank_ctrl #(
    parameter int NCH     = 12,
    parameter int OVL_DLY = 48,
    parameter int OL_QUAL = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [2*NCH-1:0] cmd_bus,
    input  logic [NCH-1:0]   ovl_flag,
    input  logic [NCH-1:0]   otemp_flag,
    input  logic [NCH-1:0]   open_flag,
    output logic [NCH-1:0]   gate_on,
    output logic [NCH-1:0]   diag_en,
    output logic [2*NCH-1:0] status_bus
);
    for (genvar k = 0; k < NCH; k++) begin : g_ch
        relay_chan #(
            .OVL_DLY (OVL_DLY),
            .OL_QUAL (OL_QUAL)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .en_i     (enable),
            .cmd_i    (cmd_bus[2*k +: 2]),
            .ovl_i    (ovl_flag[k]),
            .otemp_i  (otemp_flag[k]),
            .open_i   (open_flag[k]),
            .gate_o   (gate_on[k]),
            .diag_o   (diag_en[k]),
            .status_o (status_bus[2*k +: 2])
        );
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (gate_on == '0 && diag_en == '0 && status_bus == '0));
endmodule

// File: tb/tb_relay_bank_ctrl.sv
module tb_relay_bank_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 12;
    localparam int OVL_DLY = 4;
    localparam int OL_QUAL = 3;
    localparam logic [NCH-1:0] ALL = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b1;
    logic [2*NCH-1:0] cmd_bus = '1;
    logic [NCH-1:0] ovl_flag = '0, otemp_flag = '0, open_flag = '0;
    logic [NCH-1:0] gate_on, diag_en;
    logic [2*NCH-1:0] status_bus;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    relay_bank_ctrl #(.NCH(NCH), .OVL_DLY(OVL_DLY), .OL_QUAL(OL_QUAL)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cmd_bus(cmd_bus),
        .ovl_flag(ovl_flag), .otemp_flag(otemp_flag), .open_flag(open_flag),
        .gate_on(gate_on), .diag_en(diag_en), .status_bus(status_bus)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [2*NCH-1:0] act, input logic [2*NCH-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [2*NCH-1:0] rep(input logic [1:0] c);
        return {NCH{c}};
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; enable = 1'b1; cmd_bus = '1;
        ovl_flag = '0; otemp_flag = '0; open_flag = '0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [NCH-1:0] eg, ed;
        // R1 reset state
        rst_n = 1'b0; tick(2);
        chk("R1 gate in reset", gate_on, '0);
        chk("R1 diag in reset", diag_en, '0);
        chk("R1 status in reset", status_bus, '0);
        rst_n = 1'b1; tick(3);
        chk("R3 powerup off keeps diag off", diag_en, '0);

        // R2 R3 exhaustive command pair sweep
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                do_reset();
                cmd_bus = rep(2'(a)); tick(1);
                cmd_bus = rep(2'(b)); tick(1);
                chk($sformatf("R2 gate after %0d->%0d", a, b), gate_on, (b == 2) ? ALL : '0);
                chk($sformatf("R3 diag after %0d->%0d", a, b), diag_en, (b == 3 && a != 3) ? ALL : '0);
                chk($sformatf("R7 status after %0d->%0d", a, b), status_bus, '0);
            end
        end

        // R2 R3 mixed per-channel commands
        do_reset();
        eg = '0; ed = '0;
        for (int k = 0; k < NCH; k++) begin
            cmd_bus[2*k +: 2] = 2'(k % 4);
            eg[k] = (k % 4 == 2);
            ed[k] = (k % 4 == 3);
        end
        tick(1);
        chk("R2 mixed gate", gate_on, eg);
        chk("R3 mixed diag from powerup", diag_en, '0);
        begin
            logic [2*NCH-1:0] pat;
            pat = cmd_bus;
            cmd_bus = rep(2'b00); tick(1);
            cmd_bus = pat; tick(1);
        end
        chk("R3 mixed diag after standby", diag_en, ed);

        // R4 R6 R10 overload filter on every channel
        for (int i = 0; i < NCH; i++) begin
            do_reset();
            cmd_bus = rep(2'b10); tick(1);
            ovl_flag = ALL & (1 << i); tick(OVL_DLY - 1);
            chk("R4 short overload keeps gate", gate_on, ALL);
            ovl_flag = '0; tick(1);
            chk("R4 overload run restarts", gate_on, ALL);
            ovl_flag = ALL & (1 << i); tick(OVL_DLY - 1);
            chk("R4 one edge short of limit", gate_on, ALL);
            tick(1);
            chk("R4 overload trips at limit", gate_on, ALL & ~(1 << i));
            chk("R7 overload status bit", status_bus, 24'(1) << (2 * i));
            ovl_flag = '0;
            cmd_bus[2*i +: 2] = 2'b11; tick(1);
            chk("R6 trip holds under off", {status_bus[2*i], gate_on[i], diag_en[i]}, 3'b100);
            cmd_bus[2*i +: 2] = 2'b10; tick(2);
            chk("R6 trip holds under on", {status_bus[2*i], gate_on[i]}, 2'b10);
            cmd_bus[2*i +: 2] = 2'b00; tick(1);
            chk("R10 standby clears fault", status_bus, '0);
            cmd_bus[2*i +: 2] = 2'b10; tick(1);
            chk("R10 channel usable after clear", gate_on, ALL);
        end

        // R5 over-temperature
        do_reset();
        cmd_bus = rep(2'b10); tick(1);
        otemp_flag = 12'h020; tick(1);
        otemp_flag = '0;
        chk("R5 otemp trips only ch5 gate", gate_on, ALL & ~12'h020);
        chk("R5 otemp status", status_bus, 24'(1) << 10);
        cmd_bus[2*7 +: 2] = 2'b11; tick(1);
        otemp_flag = 12'h080; tick(1);
        otemp_flag = '0;
        chk("R5 otemp in off mode", status_bus, (24'(1) << 10) | (24'(1) << 14));
        cmd_bus = rep(2'b00); otemp_flag = ALL; tick(1);
        chk("R5 otemp ignored under standby", status_bus, '0);
        otemp_flag = '0;

        // R8 R9 open load
        do_reset();
        open_flag = 12'h008; tick(OL_QUAL + 2);
        chk("R8 no open load in powerup off", status_bus, '0);
        open_flag = '0;
        cmd_bus = rep(2'b00); tick(1);
        cmd_bus = rep(2'b11); tick(1);
        chk("R3 diag on after standby then off", diag_en, ALL);
        open_flag = 12'h008; tick(OL_QUAL - 1);
        chk("R8 short open load rejected", status_bus, '0);
        open_flag = '0; tick(1);
        open_flag = 12'h008; tick(OL_QUAL);
        chk("R8 open load latched at limit", status_bus, 24'(1) << 7);
        open_flag = '0;
        cmd_bus[2*3 +: 2] = 2'b10; tick(1);
        chk("R9 channel turns on with open load", gate_on, 12'h008);
        chk("R9 open load kept while on", status_bus, 24'(1) << 7);
        otemp_flag = 12'h008; tick(1);
        otemp_flag = '0;
        chk("R9 trip masks open load", status_bus, 24'(1) << 6);
        cmd_bus[2*3 +: 2] = 2'b00; tick(1);
        chk("R10 standby clears both bits", status_bus, '0);
        cmd_bus[2*3 +: 2] = 2'b10; open_flag = 12'h008; tick(OL_QUAL + 2);
        chk("R8 no open load while on", status_bus, '0);
        open_flag = '0;

        // R11 enable low
        cmd_bus = rep(2'b10); tick(1);
        otemp_flag = 12'h001; tick(1);
        otemp_flag = '0;
        enable = 1'b0; tick(1);
        chk("R11 enable low gate", gate_on, '0);
        chk("R11 enable low status", status_bus, '0);
        enable = 1'b1; cmd_bus = rep(2'b11); tick(2);
        chk("R11 back to powerup off no diag", diag_en, '0);
        cmd_bus = rep(2'b10); tick(1);
        chk("R11 channels usable after enable", gate_on, ALL);

        finish_run();
    end
endmodule